// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell

This block is one output cell of a programmable sum-of-products logic device. It receives four signals from the logic array: the summed product terms, an output-enable term, a global synchronous set term and a global asynchronous clear term. Two static configuration bits set the cell's behaviour. One chooses whether the sum goes through a D flip-flop or passes straight through. The other chooses whether the pin is active high or active low.

The pin is modelled as a driven value plus an output enable. A separate input carries the level that outside logic puts on the pin while the cell is not driving it. The cell also returns one feedback bit to the logic array. In registered mode that bit is the flip-flop state. In combinational mode it is the pin level, so the pin can act as an input.

A synchronous active-high reset puts the flip-flop into its power-up state, which is low. Ten copies of this cell sit beside the logic array of the device.

Top module: `omc_cell`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flip-flop state becomes 0. In registered mode the pin value is then 1 with `cfg_pos`=0 and 0 with `cfg_pos`=1.
- R2: In registered mode (`cfg_comb`=0), when neither set nor clear is active, the flip-flop state takes `sum_term` at each rising clock edge.
- R3: When `preset_term` is high and `clear_term` is low at a rising edge, the state becomes 1 whatever the value of `sum_term`.
- R4: When `clear_term` goes high, the state becomes 0 at once, without waiting for a clock edge.
- R5: When set and clear are both active, clear wins and the state stays 0.
- R6: In registered mode the pin value equals the state when `cfg_pos`=1, and its inverse when `cfg_pos`=0.
- R7: In combinational mode (`cfg_comb`=1) the pin value equals `sum_term` when `cfg_pos`=1, and its inverse when `cfg_pos`=0. It follows `sum_term` without any clock edge.
- R8: `pin_oe` is 1 exactly when `oe_term` is 1. When it is 0 the pin is high impedance.
- R9: In registered mode `fb` equals the flip-flop state, whatever the polarity, `oe_term` and `pin_in`.
- R10: In combinational mode `fb` equals the driven pin value while `oe_term` is 1, and equals `pin_in` while `oe_term` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high power-up reset |
| sum_term | input | 1 | OR of the cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Global synchronous set term |
| clear_term | input | 1 | Global asynchronous clear term |
| cfg_comb | input | 1 | 0 = registered, 1 = combinational |
| cfg_pos | input | 1 | 0 = active-low pin, 1 = active-high pin |
| pin_in | input | 1 | Level applied from outside while the pin is not driven |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback bit to the logic array |

## Verification
The assertions assume that both configuration bits change only between clock edges. They also assume that `clear_term` is stable across each sampling edge, so that a value sampled at an edge is the one that has already acted on the flip-flop. The bench changes every input on the falling edge. It raises and lowers the clear term only in the middle of a cycle, and it keeps reset high until the first edges have passed, so that no clocked check sees the state before it is first defined.

// File: rtl/ocell_pkg.sv
package ocell_pkg;
  typedef enum logic {
    MODE_REG  = 1'b0,
    MODE_COMB = 1'b1
  } ocell_mode_e;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } ocell_pol_e;

  localparam logic POWERUP_STATE = 1'b0;
endpackage

// File: rtl/ocell_storage.sv
module ocell_storage
  import ocell_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  input  logic set_sync,
  input  logic clr_async,
  output logic q
);
  // Clear acts without the clock and outranks set and data.
  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async)      q <= 1'b0;
    else if (rst)       q <= POWERUP_STATE;
    else if (set_sync)  q <= 1'b1;
    else                q <= d_in;
  end
endmodule

// File: rtl/ocell_drive.sv
module ocell_drive
  import ocell_pkg::*;
(
  input  ocell_mode_e mode,
  input  ocell_pol_e  pol,
  input  logic        q,
  input  logic        sum_in,
  input  logic        enable,
  output logic        value,
  output logic        drive_en
);
  logic raw;

  always_comb begin
    raw      = (mode == MODE_REG) ? q : sum_in;
    value    = (pol == POL_HIGH) ? raw : ~raw;
    drive_en = enable;
  end
endmodule

// File: rtl/ocell_return.sv
module ocell_return
  import ocell_pkg::*;
(
  input  ocell_mode_e mode,
  input  logic        q,
  input  logic        drive_en,
  input  logic        driven_value,
  input  logic        outside_value,
  output logic        fb_out
);
  logic pin_level;

  always_comb begin
    pin_level = drive_en ? driven_value : outside_value;
    fb_out    = (mode == MODE_REG) ? q : pin_level;
  end
endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import ocell_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sum_term,
  input  logic oe_term,
  input  logic preset_term,
  input  logic clear_term,
  input  logic cfg_comb,
  input  logic cfg_pos,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb
);
  ocell_mode_e mode;
  ocell_pol_e  pol;
  logic        q_state;

  always_comb begin
    mode = ocell_mode_e'(cfg_comb);
    pol  = ocell_pol_e'(cfg_pos);
  end

  ocell_storage u_storage (
    .clk       (clk),
    .rst       (rst),
    .d_in      (sum_term),
    .set_sync  (preset_term),
    .clr_async (clear_term),
    .q         (q_state)
  );

  ocell_drive u_drive (
    .mode     (mode),
    .pol      (pol),
    .q        (q_state),
    .sum_in   (sum_term),
    .enable   (oe_term),
    .value    (pin_out),
    .drive_en (pin_oe)
  );

  ocell_return u_return (
    .mode          (mode),
    .q             (q_state),
    .drive_en      (pin_oe),
    .driven_value  (pin_out),
    .outside_value (pin_in),
    .fb_out        (fb)
  );
endmodule

// File: rtl/omc_cell_checker.sv
module omc_cell_checker (
  input logic clk,
  input logic rst,
  input logic sum_term,
  input logic oe_term,
  input logic preset_term,
  input logic clear_term,
  input logic cfg_comb,
  input logic cfg_pos,
  input logic pin_in,
  input logic pin_out,
  input logic pin_oe,
  input logic fb,
  input logic q
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!preset_term && !clear_term) |=> (clear_term || q == $past(sum_term)));

  assert_preset_R3: assert property (@(posedge clk) disable iff (rst)
    (preset_term && !clear_term) |=> (clear_term || q));

  assert_clear_low_R4: assert property (@(posedge clk) disable iff (rst)
    (clear_term && !cfg_comb) |-> (fb == 1'b0));

  assert_reg_polarity_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_comb |-> (pin_out == (cfg_pos ? q : !q)));

  assert_comb_polarity_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_comb |-> (pin_out == (cfg_pos ? sum_term : !sum_term)));

  assert_oe_R8: assert property (@(posedge clk) disable iff (rst)
    !oe_term |-> !pin_oe);

  assert_reg_fb_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_comb |-> (fb == q));

  assert_comb_fb_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_comb && !oe_term) |-> (fb == pin_in));
endmodule

bind omc_cell omc_cell_checker u_checker (
  .clk         (clk),
  .rst         (rst),
  .sum_term    (sum_term),
  .oe_term     (oe_term),
  .preset_term (preset_term),
  .clear_term  (clear_term),
  .cfg_comb    (cfg_comb),
  .cfg_pos     (cfg_pos),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .fb          (fb),
  .q           (q_state)
);

// File: tb/test_omc_cell.sv
module test_omc_cell;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sum_term = 1'b0, oe_term = 1'b0, preset_term = 1'b0, clear_term = 1'b0;
  logic cfg_comb = 1'b0, cfg_pos = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, fb;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  omc_cell i_omc_cell (
    .clk(clk), .rst(rst), .sum_term(sum_term), .oe_term(oe_term),
    .preset_term(preset_term), .clear_term(clear_term), .cfg_comb(cfg_comb),
    .cfg_pos(cfg_pos), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  // Stimulus {comb, pos, oe, sum, preset, pin_in} then expected {pin_out, pin_oe, fb}
  localparam int NVEC = 10;
  localparam logic [8:0] VEC [NVEC] = '{
    9'b011100_111,  // reg, high, capture 1        (R2 R6 R9)
    9'b001000_110,  // reg, low, capture 0         (R2 R6 R9)
    9'b001100_011,  // reg, low, capture 1         (R2 R6)
    9'b010010_101,  // reg, preset beats sum 0     (R3 R8)
    9'b011000_010,  // reg, high, capture 0        (R2 R6)
    9'b111100_111,  // comb, high, driven fb       (R7 R10)
    9'b101100_010,  // comb, low, driven fb        (R7 R10)
    9'b110100_100,  // comb, undriven fb=pin_in 0  (R8 R10)
    9'b100001_101,  // comb, undriven fb=pin_in 1  (R7 R10)
    9'b000001_100   // reg, fb ignores pin_in      (R9)
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, active-low registered then active-high
    sum_term = 1'b1; oe_term = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 pin low-polarity after reset", pin_out, 1'b1);
    check("R1 fb after reset", fb, 1'b0);
    @(negedge clk); cfg_pos = 1'b1;
    #1;
    check("R1 pin high-polarity after reset", pin_out, 1'b0);
    check("R8 oe driven", pin_oe, 1'b1);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      {cfg_comb, cfg_pos, oe_term, sum_term, preset_term, pin_in} = VEC[i][8:3];
      @(posedge clk); #2;
      check($sformatf("vector %0d pin_out (R2 R3 R6 R7)", i), pin_out, VEC[i][2]);
      check($sformatf("vector %0d pin_oe (R8)", i), pin_oe, VEC[i][1]);
      check($sformatf("vector %0d fb (R9 R10)", i), fb, VEC[i][0]);
      @(negedge clk);
    end

    // R7: combinational pin follows sum mid-cycle, no edge
    cfg_comb = 1'b1; cfg_pos = 1'b1; oe_term = 1'b1; sum_term = 1'b0; preset_term = 1'b0;
    #1; check("R7 comb follows sum 0", pin_out, 1'b0);
    sum_term = 1'b1;
    #1; check("R7 comb follows sum 1", pin_out, 1'b1);

    // R4: asynchronous clear in registered mode
    cfg_comb = 1'b0;
    @(posedge clk); #2;
    check("R4 state set before clear", fb, 1'b1);
    #1; clear_term = 1'b1;
    #1; check("R4 clear without edge", fb, 1'b0);
    check("R4 pin active-high after clear", pin_out, 1'b0);

    // R5: clear and preset together, clear wins
    @(negedge clk); preset_term = 1'b1;
    @(posedge clk); #2;
    check("R5 clear beats preset", fb, 1'b0);
    #1; clear_term = 1'b0;
    #1; check("R5 state holds after clear release", fb, 1'b0);
    @(posedge clk); #2;
    check("R3 preset after clear release", fb, 1'b1);

    // R1: reset again with sum high
    @(negedge clk); preset_term = 1'b0; rst = 1'b1;
    @(posedge clk); #2;
    check("R1 reset clears state", fb, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check("R2 capture after reset", fb, 1'b1);

    finish_run();
  end
endmodule